// File: doc/BRIEF.md
# Serial Flash Erase-and-Program Sequencer

This block rewrites a whole serial flash over a four-wire serial link. A single `start` pulse, together with a byte count, sets off a fixed sequence. First comes one whole-chip erase. Then the data is written page by page, each page behind a 24-bit address. After every erase and every page write, the block polls the flash status until the device reports that it is idle. The bytes to be written arrive on a valid/ready stream. The stream is held off whenever the serial link is busy with commands, addresses or status polls.

The serial clock comes from a run-time divider: each high phase and each low phase lasts `div_half` system cycles. Outgoing bits and chip select change together with a rising serial-clock edge. Returned bits are captured on the falling edge. A run ends in one of two ways. It can finish with `done` after the last byte is written. It can also end with `timeout_err` when the device stays busy for more polls than `poll_limit` allows. Both flags hold until the next `start`.

Top module: `flash_rewrite_seq`

## Requirements
- R1: While `rst` is high and right after it, `cs_n` is 1, `sclk` is 0, and `busy`, `done`, `timeout_err` and `in_ready` are 0. This also holds when reset is applied in the middle of a run.
- R2: Every frame carries whole 8-bit words, most significant bit first. `mosi` changes only in a cycle where `sclk` rises. `miso` is captured when `sclk` falls.
- R3: `sclk` idles at 0 and pulses only while `cs_n` is 0. Its high phase lasts exactly `div_half` system cycles.
- R4: `cs_n` falls in the same cycle as the first `sclk` rise of a frame. It rises while `sclk` is 0. Each command uses a frame of its own.
- R5: A write-enable frame (single byte 0x06) comes before the chip-erase frame and before every page-program frame.
- R6: Exactly one chip-erase frame (single byte 0x C7, i.e. 0xC7) is sent per run, before any page-program frame.
- R7: A page-program frame is 0x02, then a 24-bit address, MSB first, then the data. The address is 0 for the first page and grows by 256 for each later page. Each frame carries 256 stream bytes in order, except the last one, which carries the remainder. A page is never split across two frames.
- R8: After an erase or a page write, the block sends status frames (0x05 followed by one read byte) until bit 0 of the read byte is 0. All other bits of that byte are ignored.
- R9: If bit 0 reads 1 in more than `poll_limit` successive polls, `timeout_err` goes to 1 and `busy` goes to 0. No further frames are sent.
- R10: `in_ready` is 1 only during the data phase of a page-program frame, between data bytes. A byte is taken in a cycle where both `in_valid` and `in_ready` are 1.
- R11: `start` clears `done` and `timeout_err` and sets `busy`. `done` rises once the last byte has been written and polled, or after the erase alone when `total_len` is 0. The flags hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run (taken only when idle) |
| total_len | input | LEN_W | Number of stream bytes to write |
| div_half | input | DIV_W | System cycles per serial-clock half period (0 is treated as 1) |
| poll_limit | input | POLL_W | Busy status reads tolerated per wait |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Stream byte accepted this cycle if valid |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished with all bytes written |
| timeout_err | output | 1 | Run stopped on a status-poll timeout |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
A broken byte counter shows up at the ports as soon as the current frame closes: the frame length is wrong, or a page runs past 256 bytes. A stale address register shows up in the header of the next page-program frame, one page later. A bad poll counter moves the timeout earlier or later, and this can be seen within `poll_limit`+1 status frames. A divider or shift fault distorts the first opcode after `start`, which a flash model reading the pins notices at once.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 8;

  localparam logic [7:0] OP_WR_ENABLE  = 8'h06;
  localparam logic [7:0] OP_CHIP_ERASE = 8'hC7;
  localparam logic [7:0] OP_PAGE_WRITE = 8'h02;
  localparam logic [7:0] OP_GET_STATUS = 8'h05;
  localparam int         BUSY_BIT      = 0;

  typedef enum logic [2:0] {
    EN_IDLE, EN_ARM, EN_SHIFT, EN_GAP, EN_CLOSE
  } eng_state_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_WREN, SQ_CMD, SQ_DATA, SQ_POLL_CMD, SQ_POLL_RD, SQ_CHECK
  } seq_state_t;
endpackage

// File: rtl/fseq_tick_gen.sv
module fseq_tick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_half,
  output logic             tick_rise,
  output logic             tick_fall
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             phase;

  assign lim = (div_half == '0) ? DIV_W'(1) : div_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      phase     <= 1'b0;
      tick_rise <= 1'b0;
      tick_fall <= 1'b0;
    end else if (cnt >= lim - DIV_W'(1)) begin
      cnt       <= '0;
      phase     <= ~phase;
      tick_rise <= ~phase;
      tick_fall <= phase;
    end else begin
      cnt       <= cnt + DIV_W'(1);
      tick_rise <= 1'b0;
      tick_fall <= 1'b0;
    end
  end
endmodule

// File: rtl/fseq_spi_engine.sv
module fseq_spi_engine
  import fseq_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_rise,
  input  logic         tick_fall,
  input  logic         req,
  input  logic [W-1:0] tx_byte,
  input  logic         last,
  input  logic         miso,
  output logic         rdy,
  output logic [W-1:0] rx_byte,
  output logic         cs_n,
  output logic         sclk,
  output logic         mosi
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

  eng_state_t       est;
  logic [W-1:0]     sh;
  logic [CNT_W-1:0] bit_left;
  logic             last_q;

  assign rdy = (est == EN_IDLE) || (est == EN_GAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      est      <= EN_IDLE;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      sh       <= '0;
      rx_byte  <= '0;
      bit_left <= '0;
      last_q   <= 1'b0;
    end else begin
      case (est)
        EN_IDLE, EN_GAP: if (req) begin
          sh     <= tx_byte;
          last_q <= last;
          est    <= EN_ARM;
        end
        EN_ARM: if (tick_rise) begin
          cs_n     <= 1'b0;
          sclk     <= 1'b1;
          mosi     <= sh[W-1];
          sh       <= {sh[W-2:0], 1'b0};
          bit_left <= CNT_W'(W - 1);
          est      <= EN_SHIFT;
        end
        EN_SHIFT: begin
          if (tick_fall) begin
            sclk    <= 1'b0;
            rx_byte <= {rx_byte[W-2:0], miso};
            if (bit_left == '0) est <= last_q ? EN_CLOSE : EN_GAP;
            else                bit_left <= bit_left - CNT_W'(1);
          end else if (tick_rise) begin
            sclk <= 1'b1;
            mosi <= sh[W-1];
            sh   <= {sh[W-2:0], 1'b0};
          end
        end
        EN_CLOSE: if (tick_rise) begin
          cs_n <= 1'b1;
          est  <= EN_IDLE;
        end
        default: est <= EN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_rewrite_seq.sv
module flash_rewrite_seq
  import fseq_pkg::*;
#(
  parameter int LEN_W      = 24,
  parameter int DIV_W      = 12,
  parameter int POLL_W     = 16,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  total_len,
  input  logic [DIV_W-1:0]  div_half,
  input  logic [POLL_W-1:0] poll_limit,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  logic              tick_rise, tick_fall;
  logic              eng_rdy, eng_req, eng_last;
  logic [7:0]        eng_byte, rx_byte;
  seq_state_t        st;
  logic [1:0]        idx;
  logic [PG_W-1:0]   pg_cnt;
  logic [LEN_W-1:0]  remain;
  logic [ADDR_W-1:0] addr;
  logic [POLL_W-1:0] polls;
  logic              erasing;
  logic              page_end;

  fseq_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div_half(div_half),
    .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  fseq_spi_engine #(.W(WORD_W)) u_eng (
    .clk(clk), .rst(rst), .tick_rise(tick_rise), .tick_fall(tick_fall),
    .req(eng_req), .tx_byte(eng_byte), .last(eng_last), .miso(miso),
    .rdy(eng_rdy), .rx_byte(rx_byte), .cs_n(cs_n), .sclk(sclk), .mosi(mosi)
  );

  assign page_end = (pg_cnt == PG_W'(PAGE_BYTES - 1)) || (remain == LEN_W'(1));
  assign in_ready = (st == SQ_DATA) && eng_rdy;

  // Byte offered to the serial engine in the current state
  always_comb begin
    eng_req  = 1'b0;
    eng_byte = 8'h00;
    eng_last = 1'b0;
    if (eng_rdy) begin
      case (st)
        SQ_WREN: begin
          eng_req = 1'b1; eng_byte = OP_WR_ENABLE; eng_last = 1'b1;
        end
        SQ_CMD: begin
          eng_req = 1'b1;
          if (erasing) begin
            eng_byte = OP_CHIP_ERASE; eng_last = 1'b1;
          end else begin
            case (idx)
              2'd0:    eng_byte = OP_PAGE_WRITE;
              2'd1:    eng_byte = addr[23:16];
              2'd2:    eng_byte = addr[15:8];
              default: eng_byte = addr[7:0];
            endcase
          end
        end
        SQ_DATA: if (in_valid) begin
          eng_req = 1'b1; eng_byte = in_data; eng_last = page_end;
        end
        SQ_POLL_CMD: begin
          eng_req = 1'b1; eng_byte = OP_GET_STATUS;
        end
        SQ_POLL_RD: begin
          eng_req = 1'b1; eng_byte = 8'h00; eng_last = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SQ_IDLE;
      busy        <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      idx         <= '0;
      pg_cnt      <= '0;
      remain      <= '0;
      addr        <= '0;
      polls       <= '0;
      erasing     <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          busy        <= 1'b1;
          done        <= 1'b0;
          timeout_err <= 1'b0;
          remain      <= total_len;
          addr        <= '0;
          erasing     <= 1'b1;
          st          <= SQ_WREN;
        end
        SQ_WREN: if (eng_rdy) begin
          idx <= '0;
          st  <= SQ_CMD;
        end
        SQ_CMD: if (eng_rdy) begin
          if (erasing) begin
            polls <= '0;
            st    <= SQ_POLL_CMD;
          end else begin
            idx <= idx + 2'd1;
            if (idx == 2'd3) begin
              pg_cnt <= '0;
              st     <= SQ_DATA;
            end
          end
        end
        SQ_DATA: if (eng_rdy && in_valid) begin
          pg_cnt <= pg_cnt + PG_W'(1);
          remain <= remain - LEN_W'(1);
          if (page_end) begin
            polls <= '0;
            st    <= SQ_POLL_CMD;
          end
        end
        SQ_POLL_CMD: if (eng_rdy) st <= SQ_POLL_RD;
        SQ_POLL_RD:  if (eng_rdy) st <= SQ_CHECK;
        SQ_CHECK: if (eng_rdy) begin
          if (!rx_byte[BUSY_BIT]) begin
            if (!erasing) addr <= addr + ADDR_W'(PAGE_BYTES);
            erasing <= 1'b0;
            if (remain == '0) begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= SQ_IDLE;
            end else begin
              st <= SQ_WREN;
            end
          end else if (polls == poll_limit) begin
            busy        <= 1'b0;
            timeout_err <= 1'b1;
            st          <= SQ_IDLE;
          end else begin
            polls <= polls + POLL_W'(1);
            st    <= SQ_POLL_CMD;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic in_ready,
  input logic busy,
  input logic done,
  input logic timeout_err
);
  // R3: serial clock pulses only inside a frame
  a_r3_clock_inside_frame: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);

  // R4: frame opens together with the first rising serial edge
  a_r4_select_with_rise: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $rose(sclk));

  // R4: frame closes with the serial clock low
  a_r4_close_clock_low: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> !sclk);

  // R2: outgoing data moves only with a rising serial edge
  a_r2_data_on_rise: assert property (@(posedge clk) disable iff (rst)
    !$stable(mosi) |-> $rose(sclk));

  // R10: stream is accepted only during a run
  a_r10_ready_in_run: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy);

  // R9: after a timeout the link is quiet and the run is over
  a_r9_quiet_after_timeout: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> (cs_n && !busy));

  // R11: completion excludes activity and error
  a_r11_done_clean: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !busy && !timeout_err));
endmodule

bind flash_rewrite_seq fseq_checker u_fseq_checker (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .in_ready(in_ready), .busy(busy), .done(done), .timeout_err(timeout_err)
);

// File: tb/tb_flash_rewrite_seq.sv
module tb_flash_rewrite_seq;
  localparam int NV = 7;
  localparam int RUN_LIMIT = 26000;
  // len, div_half, erase busy polls, program busy polls, poll_limit,
  // expected pages, expected status frames, expected timeout
  localparam int VEC [NV][8] = '{
    '{520, 2, 3, 2, 8, 3, 13, 0},
    '{256, 1, 0, 0, 4, 1,  2, 0},
    '{  1, 3, 1, 1, 2, 1,  4, 0},
    '{  0, 2, 2, 0, 4, 0,  3, 0},
    '{300, 2, 5, 0, 3, 0,  4, 1},
    '{512, 1, 0, 3, 2, 1,  4, 1},
    '{257, 4, 0, 1, 1, 2,  5, 0}
  };

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [23:0] total_len = '0;
  logic [11:0] div_half = 12'd2;
  logic [15:0] poll_limit = '0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0, miso = 1'b0;
  logic        in_ready, busy, done, timeout_err, cs_n, sclk, mosi;

  always #5 clk = ~clk;

  flash_rewrite_seq dut (
    .clk(clk), .rst(rst), .start(start), .total_len(total_len),
    .div_half(div_half), .poll_limit(poll_limit), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .busy(busy), .done(done),
    .timeout_err(timeout_err), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso)
  );

  int total = 0, bad = 0, cyc = 0;
  int run_len = 0, run_div = 2, run_eb = 0, run_pb = 0;
  int feed_idx = 0, dk = 0, bitc = 0, nb = 0, hi_start = 0, busy_left = 0;
  int n_erase = 0, n_prog = 0, n_stat = 0;
  int data_bad = 0, addr_bad = 0, size_bad = 0, order_bad = 0;
  int frame_bad = 0, clk_bad = 0, cs_bad = 0, rdy_bad = 0;
  bit acc_pend = 0, wel = 0, prev_cs = 1, prev_sclk = 0;
  logic [7:0]  sh = '0, cur_op = '0, stat_byte = '0;
  logic [23:0] fr_addr = '0;

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Stream source and flash model, all sampled away from the active edge
  always @(negedge clk) begin
    int exp_sz;
    cyc++;
    if (acc_pend) feed_idx++;
    in_valid = (feed_idx < run_len) && (cyc % 7 != 3);
    in_data  = pat(feed_idx);
    acc_pend = in_valid && in_ready;
    if (in_ready && !busy) rdy_bad++;
    if (in_ready && !cs_n && cur_op == 8'h05) rdy_bad++;

    if (!cs_n && prev_cs) begin
      bitc = 0; nb = 0; cur_op = '0; fr_addr = '0;
      stat_byte = (busy_left > 0) ? 8'h03 : 8'hA4;
      if (!sclk) cs_bad++;
    end
    if (sclk && cs_n) cs_bad++;
    if (sclk && !prev_sclk) begin
      hi_start = cyc;
      miso = (cur_op == 8'h05 && nb == 1) ? stat_byte[7-bitc] : 1'b0;
    end
    if (!sclk && prev_sclk) begin
      if (cyc - hi_start != run_div) clk_bad++;
      sh = {sh[6:0], mosi};
      bitc++;
      if (bitc == 8) begin
        if (nb == 0) cur_op = sh;
        else if (cur_op == 8'h02) begin
          if (nb < 4) fr_addr = {fr_addr[15:0], sh};
          else begin
            if (sh != pat(dk)) data_bad++;
            dk++;
          end
        end
        nb++;
        bitc = 0;
      end
    end
    if (cs_n && !prev_cs) begin
      if (bitc != 0) frame_bad++;
      case (cur_op)
        8'h06: begin wel = 1; if (nb != 1) frame_bad++; end
        8'hC7: begin
          if (!wel || n_prog > 0) order_bad++;
          if (nb != 1) frame_bad++;
          n_erase++; busy_left = run_eb; wel = 0;
        end
        8'h02: begin
          if (!wel || n_erase != 1) order_bad++;
          if (int'(fr_addr) != n_prog * 256) addr_bad++;
          exp_sz = run_len - n_prog * 256;
          if (exp_sz > 256) exp_sz = 256;
          if (nb - 4 != exp_sz) size_bad++;
          n_prog++; busy_left = run_pb; wel = 0;
        end
        8'h05: begin
          if (nb != 2) frame_bad++;
          n_stat++;
          if (busy_left > 0) busy_left--;
        end
        default: frame_bad++;
      endcase
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic clear_model(input int len, input int dv, input int eb, input int pb);
    @(posedge clk);
    run_len = len; run_div = dv; run_eb = eb; run_pb = pb;
    feed_idx = 0; acc_pend = 0; dk = 0; busy_left = 0; wel = 0;
    n_erase = 0; n_prog = 0; n_stat = 0;
    data_bad = 0; addr_bad = 0; size_bad = 0; order_bad = 0;
    frame_bad = 0; clk_bad = 0; cs_bad = 0; rdy_bad = 0;
  endtask

  task automatic run_vec(input int v);
    int n, cons;
    clear_model(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
    @(negedge clk);
    total_len = 24'(VEC[v][0]);
    div_half = 12'(VEC[v][1]);
    poll_limit = 16'(VEC[v][4]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 busy after start", busy, 1);
    chk("R11 done cleared by start", done, 0);
    n = 0;
    while (!(done || timeout_err) && n < RUN_LIMIT) begin
      @(negedge clk);
      n++;
    end
    if (n >= RUN_LIMIT) chk("watchdog run finished", 0, 1);
    repeat (40) @(negedge clk);
    cons = VEC[v][7] != 0 ? VEC[v][5] * 256 : VEC[v][0];
    if (cons > VEC[v][0]) cons = VEC[v][0];
    chk("R11 done flag", done, VEC[v][7] != 0 ? 0 : 1);
    chk("R9 timeout flag", timeout_err, VEC[v][7]);
    chk("R11 busy cleared", busy, 0);
    chk("R6 erase count", n_erase, 1);
    chk("R7 program frames", n_prog, VEC[v][5]);
    chk("R8 status frames", n_stat, VEC[v][6]);
    chk("R7 data bytes", data_bad, 0);
    chk("R7 page address", addr_bad, 0);
    chk("R7 page size", size_bad, 0);
    chk("R5 enable order", order_bad, 0);
    chk("R2 framing", frame_bad, 0);
    chk("R3 clock high phase", clk_bad, 0);
    chk("R4 chip select timing", cs_bad, 0);
    chk("R10 ready window", rdy_bad, 0);
    chk("R10 bytes consumed", feed_idx, cons);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cs_n idle", cs_n, 1);
    chk("R1 sclk idle", sclk, 0);
    chk("R1 busy idle", busy, 0);
    chk("R1 done idle", done, 0);
    chk("R1 timeout idle", timeout_err, 0);
    chk("R1 ready idle", in_ready, 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R11: flags hold with no new start
    repeat (200) @(negedge clk);
    chk("R11 done held", done, 1);
    chk("R11 link quiet while done", cs_n, 1);

    // R1: reset in the middle of a run
    clear_model(300, 1, 0, 0);
    @(negedge clk);
    total_len = 24'd300; div_half = 12'd1; poll_limit = 16'd4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (600) @(negedge clk);
    chk("R1 run active before reset", busy, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset cs_n", cs_n, 1);
    chk("R1 reset sclk", sclk, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset ready", in_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset done", done, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule